// File: doc/BRIEF.md
# Time Base and Decrementer Unit

This block keeps time for a processor core. It holds a 64-bit time base that counts up and a 32-bit signed decrementer that counts down. Both move by one on each cycle in which the shared tick enable is high. Software reaches either register through a small register port. Writes take effect on the next clock edge. Reads are combinational from the current register values.

The decrementer raises a level interrupt request toward the core. The trigger is a change of the decrementer's sign from non-negative to negative. That change can come from counting down through zero, or from software loading a negative value over a non-negative one. The request stays high until the core returns an acknowledge. Any new decrementer load withdraws a request that is still outstanding and judges the situation again against the new value.

Top module: `tbd_timer_unit`

## Requirements
- R1: After reset the time base and the decrementer both read zero and `irq_req` is low.
- R2: On each cycle with `tick_en` high and no write to it, the time base increases by one. It rolls over from all ones to zero with no side effect.
- R3: On each cycle with `tick_en` high and no write to it, the decrementer decreases by one. It rolls from 32'h8000_0000 to 32'h7FFF_FFFF without raising a request.
- R4: With `reg_wr` high, `reg_sel`=0 loads the time base from all 64 bits of `reg_wdata`, and `reg_sel`=1 loads the decrementer from `reg_wdata[31:0]`. The written value is read back in the next cycle even if `tick_en` was high, and the other register still ticks. `rd_sel`=0 reads the time base; `rd_sel`=1 reads the decrementer sign-extended to 64 bits.
- R5: A tick that takes the decrementer from 0 to -1 sets `irq_req` in the following cycle. After a load of a non-negative value V, with no later load, the request rises after the (V+1)-th tick.
- R6: Loading a negative value while the decrementer is non-negative sets `irq_req` after the first tick that follows the write cycle.
- R7: Loading a negative value while the decrementer is already negative raises no request.
- R8: Any decrementer load clears an outstanding `irq_req` in the next cycle. It also withdraws an event armed by an earlier load. A time-base write leaves the request alone.
- R9: Without `irq_ack`, `irq_req` stays high on every following cycle. `irq_ack` high clears it in the next cycle, unless a new decrementer event occurs in the same cycle, which keeps it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Advance both counters this cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 time base, 1 decrementer |
| reg_wdata | input | 64 | Write data; the decrementer takes bits 31:0 |
| rd_sel | input | 1 | Read source: 0 time base, 1 decrementer |
| rd_data | output | 64 | Selected register; the decrementer is sign-extended |
| irq_req | output | 1 | Decrementer interrupt request, level |
| irq_ack | input | 1 | Core accepts the request |

## Verification
A stale or wrong counter value shows on `rd_data` in the very next cycle, because reads are combinational from the registers. A lost or spurious armed-event flag stays hidden until the next tick. At that tick `irq_req` either fails to rise after a negative load, or rises when it should not. A wrong pending bit shows on `irq_req` one cycle after the event, load or acknowledge that should have moved it.

// File: rtl/tbd_pkg.sv
package tbd_pkg;
    typedef enum logic {
        SEL_TIMEBASE = 1'b0,
        SEL_DECR     = 1'b1
    } tbd_sel_e;
endpackage

// File: rtl/tbd_timebase.sv
module tbd_timebase #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] count_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } tb_state_t;

    tb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.cnt = load_val_i;
        end else if (tick_i) begin
            st_d.cnt = st_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.cnt;

    p_tb_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i) |=> count_o == $past(count_o) + W'(1));

    p_tb_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> count_o == $past(load_val_i));
endmodule

// File: rtl/tbd_decrementer.sv
module tbd_decrementer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] count_o,
    output logic         fire_o
);
    localparam int SIGN = W - 1;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         arm;
    } dec_state_t;

    dec_state_t st_d, st_q;
    logic       at_zero;

    assign at_zero = (st_q.cnt == '0);

    always_comb begin
        st_d   = st_q;
        fire_o = 1'b0;
        if (load_i) begin
            st_d.cnt = load_val_i;
            st_d.arm = load_val_i[SIGN] && !st_q.cnt[SIGN];
        end else if (tick_i) begin
            st_d.cnt = st_q.cnt - W'(1);
            st_d.arm = 1'b0;
            fire_o   = at_zero || st_q.arm;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.cnt;

    p_dec_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i) |=> count_o == $past(count_o) - W'(1));

    p_dec_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> count_o == $past(load_val_i));

    p_neg_over_pos_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && load_val_i[SIGN] && !count_o[SIGN])
        |=> (!tick_i || load_i || fire_o));

    p_neg_over_neg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && load_val_i[SIGN] && count_o[SIGN]) |=> !fire_o);
endmodule

// File: rtl/tbd_irq_hold.sv
module tbd_irq_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clear_i,
    input  logic ack_i,
    output logic irq_o
);
    typedef struct packed {
        logic pend;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.pend = 1'b0;
        end else if (set_i) begin
            st_d.pend = 1'b1;
        end else if (ack_i) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.pend;

    p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clear_i) |=> irq_o);

    p_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !irq_o);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ack_i && !clear_i) |=> irq_o);

    p_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !set_i) |=> !irq_o);
endmodule

// File: rtl/tbd_timer_unit.sv
module tbd_timer_unit #(
    parameter int TB_W  = 64,
    parameter int DEC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_en,
    input  logic            reg_wr,
    input  logic            reg_sel,
    input  logic [TB_W-1:0] reg_wdata,
    input  logic            rd_sel,
    output logic [TB_W-1:0] rd_data,
    output logic            irq_req,
    input  logic            irq_ack
);
    import tbd_pkg::*;

    localparam int EXT_W = TB_W - DEC_W;

    logic             tb_load, dec_load, dec_fire;
    logic [TB_W-1:0]  tb_val;
    logic [DEC_W-1:0] dec_val;

    assign tb_load  = reg_wr && (tbd_sel_e'(reg_sel) == SEL_TIMEBASE);
    assign dec_load = reg_wr && (tbd_sel_e'(reg_sel) == SEL_DECR);

    tbd_timebase #(.W(TB_W)) u_tb (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_en),
        .load_i     (tb_load),
        .load_val_i (reg_wdata),
        .count_o    (tb_val)
    );

    tbd_decrementer #(.W(DEC_W)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_en),
        .load_i     (dec_load),
        .load_val_i (reg_wdata[DEC_W-1:0]),
        .count_o    (dec_val),
        .fire_o     (dec_fire)
    );

    tbd_irq_hold u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (dec_fire),
        .clear_i (dec_load),
        .ack_i   (irq_ack),
        .irq_o   (irq_req)
    );

    always_comb begin
        if (tbd_sel_e'(rd_sel) == SEL_DECR) begin
            rd_data = {{EXT_W{dec_val[DEC_W-1]}}, dec_val};
        end else begin
            rd_data = tb_val;
        end
    end

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (tb_val == '0 && dec_val == '0 && !irq_req));

    p_tbwr_keeps_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tb_load && irq_req && !irq_ack) |=> irq_req);
endmodule

// File: tb/tbd_timer_unit_tb.sv
module tbd_timer_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick_en, reg_wr, reg_sel, rd_sel, irq_ack;
    logic [63:0] reg_wdata, rd_data;
    logic        irq_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [63:0] m_tb;
    logic [31:0] m_dec;
    logic        m_arm, m_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    tbd_timer_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data),
        .irq_req   (irq_req),
        .irq_ack   (irq_ack)
    );

    function automatic logic [63:0] sext(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        rd_sel = 1'b0; #1;
        chk("R2 time base", rd_data, m_tb);
        rd_sel = 1'b1; #1;
        chk("R3 decrementer", rd_data, sext(m_dec));
        chk("R9 irq level", {63'd0, irq_req}, {63'd0, m_irq});
    endtask

    // Expected next state from the requirements; called at a negedge with inputs.
    task automatic drive(input logic wr, input logic sel, input logic [63:0] wd,
                         input logic tk, input logic ak);
        logic fire;
        reg_wr = wr; reg_sel = sel; reg_wdata = wd; tick_en = tk; irq_ack = ak;
        fire = 1'b0;
        if (wr && !sel) m_tb = wd;
        else if (tk) m_tb = m_tb + 64'd1;
        if (wr && sel) begin
            m_arm = wd[31] && !m_dec[31];
            m_dec = wd[31:0];
            m_irq = 1'b0;
        end else begin
            if (tk) begin
                fire  = (m_dec == 32'd0) || m_arm;
                m_dec = m_dec - 32'd1;
                m_arm = 1'b0;
            end
            if (fire) m_irq = 1'b1;
            else if (ak) m_irq = 1'b0;
        end
        @(negedge clk);
        reg_wr = 1'b0; tick_en = 1'b0; irq_ack = 1'b0;
        compare_all();
    endtask

    task automatic rd_dec(input string tag, input logic [31:0] exp);
        rd_sel = 1'b1; #1;
        chk(tag, rd_data, sext(exp));
    endtask

    task automatic rd_tb(input string tag, input logic [63:0] exp);
        rd_sel = 1'b0; #1;
        chk(tag, rd_data, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; tick_en = 1'b0; reg_wr = 1'b0; reg_sel = 1'b0;
        reg_wdata = '0; rd_sel = 1'b0; irq_ack = 1'b0;
        m_tb = '0; m_dec = '0; m_arm = 1'b0; m_irq = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd_tb("R1 time base after reset", 64'd0);
        rd_dec("R1 decrementer after reset", 32'd0);
        chk("R1 irq after reset", {63'd0, irq_req}, 64'd0);

        // R4: write beats tick; the decrementer still ticks (0 -> -1 fires)
        drive(1'b1, 1'b0, 64'h0123_4567_89AB_CDEF, 1'b1, 1'b0);
        rd_tb("R4 write priority", 64'h0123_4567_89AB_CDEF);
        rd_dec("R4 other register ticks", 32'hFFFF_FFFF);
        drive(1'b0, 1'b0, '0, 1'b1, 1'b0);
        rd_tb("R2 count after write", 64'h0123_4567_89AB_CDF0);

        // R2: silent wrap
        drive(1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0);
        drive(1'b0, 1'b0, '0, 1'b1, 1'b0);
        rd_tb("R2 wrap to zero", 64'd0);

        // R5: load 3 -> request after the 4th tick
        drive(1'b0, 1'b0, '0, 1'b0, 1'b1);
        drive(1'b1, 1'b1, 64'd3, 1'b0, 1'b0);
        for (int i = 1; i <= 3; i++) begin
            drive(1'b0, 1'b0, '0, 1'b1, 1'b0);
            chk("R5 no request before crossing", {63'd0, irq_req}, 64'd0);
        end
        drive(1'b0, 1'b0, '0, 1'b1, 1'b0);
        chk("R5 request after V+1 ticks", {63'd0, irq_req}, 64'd1);

        // R9: held without acknowledge, cleared by it
        for (int i = 0; i < 3; i++) begin
            drive(1'b0, 1'b0, '0, 1'b0, 1'b0);
            chk("R9 request held", {63'd0, irq_req}, 64'd1);
        end
        drive(1'b0, 1'b0, '0, 1'b0, 1'b1);
        chk("R9 acknowledge clears", {63'd0, irq_req}, 64'd0);

        // R3 and R7: negative load over negative, then wrap upward
        drive(1'b1, 1'b1, 64'h0000_0000_8000_0000, 1'b0, 1'b0);
        drive(1'b0, 1'b0, '0, 1'b1, 1'b0);
        rd_dec("R3 wrap to most positive", 32'h7FFF_FFFF);
        chk("R7 no request on negative over negative", {63'd0, irq_req}, 64'd0);

        // R6: negative load over non-negative fires after next tick
        drive(1'b1, 1'b1, 64'h0000_0000_FFFF_FFFE, 1'b0, 1'b0);
        drive(1'b0, 1'b0, '0, 1'b0, 1'b0);
        chk("R6 not before a tick", {63'd0, irq_req}, 64'd0);
        drive(1'b0, 1'b0, '0, 1'b1, 1'b0);
        chk("R6 request after first tick", {63'd0, irq_req}, 64'd1);

        // R8: time-base write keeps it, decrementer load cancels it
        drive(1'b1, 1'b0, 64'd77, 1'b0, 1'b0);
        chk("R8 time-base write keeps request", {63'd0, irq_req}, 64'd1);
        drive(1'b1, 1'b1, 64'd10, 1'b1, 1'b0);
        chk("R8 load cancels request", {63'd0, irq_req}, 64'd0);
        rd_dec("R4 decrementer write priority", 32'd10);

        // R8: armed event withdrawn by a later load
        drive(1'b1, 1'b1, 64'h0000_0000_FFFF_FFF0, 1'b0, 1'b0);
        drive(1'b1, 1'b1, 64'd50, 1'b0, 1'b0);
        drive(1'b0, 1'b0, '0, 1'b1, 1'b0);
        chk("R8 armed event withdrawn", {63'd0, irq_req}, 64'd0);

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            logic        wr, sel, tk, ak;
            logic [63:0] wd;
            wr  = ($urandom_range(0, 7) == 0);
            sel = ($urandom_range(0, 3) != 0);
            tk  = ($urandom_range(0, 3) != 0);
            ak  = ($urandom_range(0, 5) == 0);
            if (sel) wd = sext(32'($urandom_range(0, 24)) - 32'd12);
            else     wd = {$urandom, $urandom};
            drive(wr, sel, wd, tk, ak);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule